// File: doc/BRIEF.md
# Dual-Style Four-Channel Host Bus Front End

This block is the processor-facing side of a four-channel asynchronous serial controller. A strap input chooses one of two bus styles. In the split-strobe style, each channel has its own active-low select, with separate active-low read and write strobes. In the shared-select style, one active-low select is combined with a read/not-write line, and two further address bits name the channel. The same physical pins are reused between the two styles, so the strap changes what each pin means.

Each access carries a 3-bit register offset. The block routes it to the chosen channel's register file. When bit 7 of the line-control byte is set, offsets 0 and 1 are redirected to the two bytes of the divisor latch. The block also turns the reset pin into an internal active-low reset, with a polarity that depends on the style. It then either presents each channel's interrupt separately, or merges all of them into one open-drain request.

The per-channel register files here are placeholders. They hold configuration bytes and turn a 4-bit interrupt-source vector into a pending flag. They have no serial datapath.

All bus pins are sampled on `clk_i`.

Top module: `quad_host_if`

## Requirements
- R1: With `mode16_i`=1, a channel i is addressed only when `sel_pin_i[i]` is the single low bit of `sel_pin_i`. If no bit is low, or more than one is low, the access is ignored: no data is driven and no register changes.
- R2: With `mode16_i`=0, the shared select is `sel_pin_i[0]` (active low). The channel number is {`sel_pin_i[2]`,`sel_pin_i[1]`}: 0 is A, 1 is B, 2 is C and 3 is D. `sel_pin_i[3]` is ignored. When `sel_pin_i[0]`=1 there is no access.
- R3: `data_oe_o` is 1 only during a valid read. In the split-strobe style that means `rd_n_i`=0 and `wr_rw_i`=1. In the shared-select style it means `wr_rw_i`=1 with the select low. During a valid read, `data_o` shows the addressed register in the same cycle; at all other times `data_o` is 0.
- R4: A write is committed at the clock edge where the access is first seen to have ended. In the split-strobe style that is `wr_rw_i` returning high; in the shared-select style it is the select returning high. The committed address, data and channel are those sampled in the last active cycle. Only that channel changes.
- R5: Internal reset is active while `rst_pin_i`=1 in the split-strobe style, and while `rst_pin_i`=0 in the shared-select style.
- R6: After reset, every channel reads as follows: offset 7 gives 0xFF, offset 5 gives 0x60, offset 6 gives 0x00, offset 2 gives 0x01 when no source is enabled, and offsets 0, 1, 3 and 4 give 0x00. The divisor bytes also read 0x00.
- R7: When bit 7 of offset 3 is 1, offsets 0 and 1 read and write the low and high divisor bytes. When that bit is 0, offset 0 is a holding byte that reads back its last written value, and offset 1 is the enable register.
- R8: At offset 1, only bits 3:0 are stored, and bits 7:4 read as 0. At offset 4, only bits 4:0 are stored. Writes to offsets 2, 5 and 6 have no effect.
- R9: A channel's interrupt is pending when (its 4-bit source field, `irq_src_i[4i+3:4i]`, AND enable bits 3:0) is non-zero. Offset 2 reads 0x00 while the interrupt is pending and 0x01 otherwise.
- R10: In the split-strobe style, `int_o[i]` equals channel i's pending flag. `int_oe_o[i]` is 1 when `intsel_i`=1, or when bit 3 of channel i's offset-4 register is 1.
- R11: In the shared-select style, `int_o` is all zeros and `int_oe_o[3:1]` is zero. `int_oe_o[0]` is 1 (pulling the request low) when any channel is pending. `intsel_i` and bit 3 of offset 4 have no effect.
- R12: Offset 7 is a full 8-bit scratch byte that reads back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_pin_i | input | 1 | Reset pin; its polarity depends on the style |
| mode16_i | input | 1 | 1 selects split-strobe style, 0 selects shared-select style |
| intsel_i | input | 1 | Forces interrupt outputs on (split-strobe style only) |
| sel_pin_i | input | 4 | Per-channel selects, or shared select plus channel address |
| rd_n_i | input | 1 | Read strobe, active low (split-strobe style only) |
| wr_rw_i | input | 1 | Write strobe (active low), or read/not-write line |
| addr_i | input | 3 | Register offset |
| data_i | input | 8 | Write data |
| data_o | output | 8 | Read data |
| data_oe_o | output | 1 | Read data enable |
| irq_src_i | input | 16 | Four interrupt-source bits per channel |
| int_o | output | 4 | Interrupt levels |
| int_oe_o | output | 4 | Interrupt output enables (lane 0 is the open-drain request in shared-select style) |

## Verification
The hardest case to reach is a write that must leave every register alone. This covers writes with zero or several selects low, writes in the shared-select style with the select high, and writes to offsets 2, 5 and 6. Any of these can only be seen through later reads. The random stimulus therefore mixes such ignored writes with reads of every offset on every channel, and all reads are compared against a bench model. The divisor-latch alias is another case that is hard to reach. It depends on an earlier line-control write, so random line-control writes keep toggling bit 7 between random divisor and holding-byte accesses. A directed sequence also checks the reset pin in both polarities.

// File: rtl/hbi_pkg.sv
package hbi_pkg;
  localparam int DW        = 8;
  localparam int AW        = 3;
  localparam int SRC_W     = 4;
  localparam int DLAB_BIT  = 7;
  localparam int IRQ_OE_BIT = 3;
  localparam logic [DW-1:0] LST_RESET = 8'h60;
  localparam logic [DW-1:0] SCR_RESET = 8'hFF;

  typedef enum logic [AW-1:0] {
    OFS_DATA = 3'd0,
    OFS_IEN  = 3'd1,
    OFS_IST  = 3'd2,
    OFS_LCTL = 3'd3,
    OFS_MCTL = 3'd4,
    OFS_LST  = 3'd5,
    OFS_MST  = 3'd6,
    OFS_SCR  = 3'd7
  } ofs_e;
endpackage

// File: rtl/hbi_decode.sv
module hbi_decode #(
  parameter int NUM_CH = 4,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic              mode16_i,
  input  logic [NUM_CH-1:0] sel_pin_i,
  input  logic              rd_n_i,
  input  logic              wr_rw_i,
  output logic              rd_o,
  output logic              wr_o,
  output logic [CH_W-1:0]   ch_o
);
  logic [NUM_CH-1:0] low16;
  logic              ok16, ok68;
  logic [CH_W-1:0]   idx16;

  assign low16 = ~sel_pin_i;
  assign ok16  = $onehot(low16);
  assign ok68  = ~sel_pin_i[0];

  always_comb begin
    idx16 = '0;
    for (int i = 0; i < NUM_CH; i++)
      if (low16[i]) idx16 = CH_W'(i);
  end

  always_comb begin
    if (mode16_i) begin
      rd_o = ok16 & ~rd_n_i & wr_rw_i;
      wr_o = ok16 & ~wr_rw_i;
      ch_o = idx16;
    end else begin
      rd_o = ok68 & wr_rw_i;
      wr_o = ok68 & ~wr_rw_i;
      ch_o = sel_pin_i[CH_W:1];
    end
  end
endmodule

// File: rtl/hbi_wr_commit.sv
module hbi_wr_commit
  import hbi_pkg::*;
#(
  parameter int NUM_CH = 4,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_act_i,
  input  logic [CH_W-1:0] ch_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [DW-1:0]   data_i,
  output logic            we_o,
  output logic [CH_W-1:0] we_ch_o,
  output logic [AW-1:0]   we_addr_o,
  output logic [DW-1:0]   we_data_o
);
  logic prev_act;

  // hold the last active-cycle write, commit when the access ends
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_act  <= 1'b0;
      we_ch_o   <= '0;
      we_addr_o <= '0;
      we_data_o <= '0;
    end else begin
      prev_act <= wr_act_i;
      if (wr_act_i) begin
        we_ch_o   <= ch_i;
        we_addr_o <= addr_i;
        we_data_o <= data_i;
      end
    end
  end

  assign we_o = prev_act & ~wr_act_i;
endmodule

// File: rtl/hbi_chan_regs.sv
module hbi_chan_regs
  import hbi_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [AW-1:0]    raddr_i,
  input  logic [SRC_W-1:0] src_i,
  output logic [DW-1:0]    rdata_o,
  output logic             irq_o,
  output logic             int_en_o
);
  logic [DW-1:0]    hold_q, lctl_q, scr_q, div_lo_q, div_hi_q;
  logic [SRC_W-1:0] ien_q;
  logic [4:0]       mctl_q;
  logic             dlab;

  assign dlab = lctl_q[DLAB_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q   <= '0;
      lctl_q   <= '0;
      scr_q    <= SCR_RESET;
      div_lo_q <= '0;
      div_hi_q <= '0;
      ien_q    <= '0;
      mctl_q   <= '0;
    end else if (we_i) begin
      case (waddr_i)
        OFS_DATA: if (dlab) div_lo_q <= wdata_i; else hold_q <= wdata_i;
        OFS_IEN:  if (dlab) div_hi_q <= wdata_i; else ien_q <= wdata_i[SRC_W-1:0];
        OFS_LCTL: lctl_q <= wdata_i;
        OFS_MCTL: mctl_q <= wdata_i[4:0];
        OFS_SCR:  scr_q  <= wdata_i;
        default:  ;
      endcase
    end
  end

  assign irq_o    = |(src_i & ien_q);
  assign int_en_o = mctl_q[IRQ_OE_BIT];

  always_comb begin
    case (raddr_i)
      OFS_DATA: rdata_o = dlab ? div_lo_q : hold_q;
      OFS_IEN:  rdata_o = dlab ? div_hi_q : {{(DW-SRC_W){1'b0}}, ien_q};
      OFS_IST:  rdata_o = {{(DW-1){1'b0}}, ~irq_o};
      OFS_LCTL: rdata_o = lctl_q;
      OFS_MCTL: rdata_o = {3'b000, mctl_q};
      OFS_LST:  rdata_o = LST_RESET;
      OFS_MST:  rdata_o = '0;
      default:  rdata_o = scr_q;
    endcase
  end
endmodule

// File: rtl/hbi_irq_route.sv
module hbi_irq_route #(
  parameter int NUM_CH = 4
) (
  input  logic              mode16_i,
  input  logic              intsel_i,
  input  logic [NUM_CH-1:0] chan_irq_i,
  input  logic [NUM_CH-1:0] chan_en_i,
  output logic [NUM_CH-1:0] int_o,
  output logic [NUM_CH-1:0] int_oe_o
);
  always_comb begin
    if (mode16_i) begin
      int_o    = chan_irq_i;
      int_oe_o = chan_en_i | {NUM_CH{intsel_i}};
    end else begin
      // open drain: level fixed low, enable pulls the shared line
      int_o    = '0;
      int_oe_o = '0;
      int_oe_o[0] = |chan_irq_i;
    end
  end
endmodule

// File: rtl/quad_host_if.sv
module quad_host_if
  import hbi_pkg::*;
#(
  parameter int NUM_CH = 4,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic                    clk_i,
  input  logic                    rst_pin_i,
  input  logic                    mode16_i,
  input  logic                    intsel_i,
  input  logic [NUM_CH-1:0]       sel_pin_i,
  input  logic                    rd_n_i,
  input  logic                    wr_rw_i,
  input  logic [AW-1:0]           addr_i,
  input  logic [DW-1:0]           data_i,
  output logic [DW-1:0]           data_o,
  output logic                    data_oe_o,
  input  logic [NUM_CH*SRC_W-1:0] irq_src_i,
  output logic [NUM_CH-1:0]       int_o,
  output logic [NUM_CH-1:0]       int_oe_o
);
  logic              rst_n;
  logic              rd_act, wr_act, we;
  logic [CH_W-1:0]   acc_ch, we_ch;
  logic [AW-1:0]     we_addr;
  logic [DW-1:0]     we_data;
  logic [DW-1:0]     rdata [NUM_CH];
  logic [NUM_CH-1:0] chan_irq, chan_en;

  assign rst_n = mode16_i ? ~rst_pin_i : rst_pin_i;

  hbi_decode #(.NUM_CH(NUM_CH)) i_decode (
    .mode16_i (mode16_i),
    .sel_pin_i(sel_pin_i),
    .rd_n_i   (rd_n_i),
    .wr_rw_i  (wr_rw_i),
    .rd_o     (rd_act),
    .wr_o     (wr_act),
    .ch_o     (acc_ch)
  );

  hbi_wr_commit #(.NUM_CH(NUM_CH)) i_commit (
    .clk_i    (clk_i),
    .rst_ni   (rst_n),
    .wr_act_i (wr_act),
    .ch_i     (acc_ch),
    .addr_i   (addr_i),
    .data_i   (data_i),
    .we_o     (we),
    .we_ch_o  (we_ch),
    .we_addr_o(we_addr),
    .we_data_o(we_data)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    hbi_chan_regs i_regs (
      .clk_i   (clk_i),
      .rst_ni  (rst_n),
      .we_i    (we && (we_ch == CH_W'(g))),
      .waddr_i (we_addr),
      .wdata_i (we_data),
      .raddr_i (addr_i),
      .src_i   (irq_src_i[g*SRC_W +: SRC_W]),
      .rdata_o (rdata[g]),
      .irq_o   (chan_irq[g]),
      .int_en_o(chan_en[g])
    );
  end

  assign data_oe_o = rd_act;
  assign data_o    = rd_act ? rdata[acc_ch] : '0;

  hbi_irq_route #(.NUM_CH(NUM_CH)) i_irq (
    .mode16_i  (mode16_i),
    .intsel_i  (intsel_i),
    .chan_irq_i(chan_irq),
    .chan_en_i (chan_en),
    .int_o     (int_o),
    .int_oe_o  (int_oe_o)
  );
endmodule

// File: rtl/quad_host_if_chk.sv
module quad_host_if_chk
  import hbi_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input logic                    clk_i,
  input logic                    rst_pin_i,
  input logic                    mode16_i,
  input logic                    intsel_i,
  input logic [NUM_CH-1:0]       sel_pin_i,
  input logic                    rd_n_i,
  input logic                    wr_rw_i,
  input logic [AW-1:0]           addr_i,
  input logic [DW-1:0]           data_i,
  input logic [DW-1:0]           data_o,
  input logic                    data_oe_o,
  input logic [NUM_CH*SRC_W-1:0] irq_src_i,
  input logic [NUM_CH-1:0]       int_o,
  input logic [NUM_CH-1:0]       int_oe_o
);
  logic rst_nc;
  assign rst_nc = mode16_i ? !rst_pin_i : rst_pin_i;

  a_r3_oe_only_on_read: assert property (@(posedge clk_i) disable iff (!rst_nc)
    data_oe_o |-> (mode16_i ? (!rd_n_i && wr_rw_i && $onehot(~sel_pin_i))
                            : (!sel_pin_i[0] && wr_rw_i)));

  a_r3_bus_quiet: assert property (@(posedge clk_i) disable iff (!rst_nc)
    !data_oe_o |-> (data_o == '0));

  a_r3_held_read_stable: assert property (@(posedge clk_i) disable iff (!rst_nc)
    (data_oe_o && $past(data_oe_o) && $stable(sel_pin_i) && $stable(addr_i)
     && $stable(mode16_i) && addr_i != OFS_IST) |-> $stable(data_o));

  a_r10_intsel_forces_oe: assert property (@(posedge clk_i) disable iff (!rst_nc)
    (mode16_i && intsel_i) |-> (&int_oe_o));

  a_r11_single_request: assert property (@(posedge clk_i) disable iff (!rst_nc)
    !mode16_i |-> (int_o == '0 && int_oe_o[NUM_CH-1:1] == '0));
endmodule

bind quad_host_if quad_host_if_chk #(.NUM_CH(NUM_CH)) i_chk (.*);

// File: tb/test_quad_host_if.sv
module test_quad_host_if;
  localparam int CLK_T = 10;
  localparam int NCH = 4;

  logic        clk = 1'b0;
  logic        rst_pin, mode16, intsel, rd_n, wr_rw;
  logic [3:0]  sel_pin;
  logic [2:0]  addr;
  logic [7:0]  data_in, data_out;
  logic        data_oe;
  logic [15:0] irq_src;
  logic [3:0]  int_lv, int_oe;

  int n_vec = 0, n_bad = 0;

  logic [7:0] m_hold[NCH], m_lcr[NCH], m_spr[NCH], m_dll[NCH], m_dlm[NCH];
  logic [3:0] m_ier[NCH];
  logic [4:0] m_mcr[NCH];

  quad_host_if i_quad_host_if (
    .clk_i(clk), .rst_pin_i(rst_pin), .mode16_i(mode16), .intsel_i(intsel),
    .sel_pin_i(sel_pin), .rd_n_i(rd_n), .wr_rw_i(wr_rw), .addr_i(addr),
    .data_i(data_in), .data_o(data_out), .data_oe_o(data_oe),
    .irq_src_i(irq_src), .int_o(int_lv), .int_oe_o(int_oe)
  );

  always #(CLK_T/2) clk = ~clk;

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int c = 0; c < NCH; c++) begin
      m_hold[c] = 0; m_lcr[c] = 0; m_spr[c] = 8'hFF; m_dll[c] = 0;
      m_dlm[c] = 0; m_ier[c] = 0; m_mcr[c] = 0;
    end
  endtask

  function automatic logic chan_pend(int c);
    return |(irq_src[c*4 +: 4] & m_ier[c]);
  endfunction

  function automatic logic [7:0] exp_rd(int c, logic [2:0] a);
    case (a)
      3'd0: return m_lcr[c][7] ? m_dll[c] : m_hold[c];
      3'd1: return m_lcr[c][7] ? m_dlm[c] : {4'b0, m_ier[c]};
      3'd2: return {7'b0, ~chan_pend(c)};
      3'd3: return m_lcr[c];
      3'd4: return {3'b0, m_mcr[c]};
      3'd5: return 8'h60;
      3'd6: return 8'h00;
      default: return m_spr[c];
    endcase
  endfunction

  task automatic model_write(int c, logic [2:0] a, logic [7:0] d);
    case (a)
      3'd0: if (m_lcr[c][7]) m_dll[c] = d; else m_hold[c] = d;
      3'd1: if (m_lcr[c][7]) m_dlm[c] = d; else m_ier[c] = d[3:0];
      3'd3: m_lcr[c] = d;
      3'd4: m_mcr[c] = d[4:0];
      3'd7: m_spr[c] = d;
      default: ;
    endcase
  endtask

  task automatic bus_idle();
    sel_pin = 4'hF; rd_n = 1'b1; wr_rw = 1'b1;
  endtask

  task automatic drive_sel(int c, bit good);
    if (mode16)
      sel_pin = good ? ~(4'b0001 << c) : (($urandom % 2) ? 4'h0 : 4'h3);
    else
      sel_pin = {1'($urandom), 1'(c >> 1), 1'(c), ~good};
  endtask

  task automatic do_write(int c, logic [2:0] a, logic [7:0] d, bit good);
    @(negedge clk);
    addr = a; data_in = d; drive_sel(c, good); wr_rw = 1'b0;
    repeat (2) @(negedge clk);
    if (mode16) wr_rw = 1'b1; else sel_pin[0] = 1'b1;
    @(negedge clk);
    bus_idle();
    if (good) model_write(c, a, d);
  endtask

  task automatic do_read(int c, logic [2:0] a, bit good, string req);
    @(negedge clk);
    addr = a; drive_sel(c, good); wr_rw = 1'b1;
    if (mode16) rd_n = 1'b0;
    #(CLK_T/4);
    chk({req, " oe"}, 16'(data_oe), 16'(good));
    chk({req, " data"}, 16'(data_out), good ? 16'(exp_rd(c, a)) : 16'h0);
    @(negedge clk);
    bus_idle();
  endtask

  task automatic check_ints();
    logic [3:0] el, eo;
    #1;
    el = '0; eo = '0;
    if (mode16) begin
      for (int c = 0; c < NCH; c++) begin
        el[c] = chan_pend(c);
        eo[c] = intsel | m_mcr[c][3];
      end
      chk("R10 int level", 16'(int_lv), 16'(el));
      chk("R10 int enable", 16'(int_oe), 16'(eo));
    end else begin
      for (int c = 0; c < NCH; c++) eo[0] = eo[0] | chan_pend(c);
      chk("R11 merged request", {int_lv, int_oe}, {4'h0, eo});
    end
  endtask

  task automatic enter_mode(bit m);
    @(negedge clk);
    bus_idle();
    mode16 = m; rst_pin = m ? 1'b1 : 1'b0;
    repeat (2) @(negedge clk);
    rst_pin = m ? 1'b0 : 1'b1;
    model_reset();
  endtask

  task automatic random_phase(int n);
    for (int k = 0; k < n; k++) begin
      int c = $urandom % NCH;
      int op = $urandom % 20;
      logic [2:0] a = 3'($urandom);
      logic [7:0] d = 8'($urandom);
      irq_src = 16'($urandom); intsel = 1'($urandom);
      if (op < 8)       do_write(c, a, d, 1'b1);
      else if (op < 10) do_write(c, a, d, 1'b0);
      else if (op < 18) do_read(c, a, 1'b1, mode16 ? "R1 R3 R8 R9 read" : "R2 R3 R8 R9 read");
      else              do_read(c, a, 1'b0, mode16 ? "R1 bad select" : "R2 select high");
      check_ints();
    end
    for (int c = 0; c < NCH; c++)
      for (int a = 0; a < 8; a++)
        do_read(c, 3'(a), 1'b1, "R4 R8 sweep");
  endtask

  task automatic directed();
    // R6 reset contents, with no source enabled
    irq_src = 16'hFFFF;
    for (int c = 0; c < NCH; c++)
      for (int a = 0; a < 8; a++)
        do_read(c, 3'(a), 1'b1, "R6 reset value");
    // R12 scratch and R4 channel isolation
    do_write(2, 3'd7, 8'h5A, 1'b1);
    do_read(2, 3'd7, 1'b1, "R12 scratch");
    do_read(1, 3'd7, 1'b1, "R4 other channel untouched");
    // R7 divisor alias
    do_write(1, 3'd3, 8'h83, 1'b1);
    do_write(1, 3'd0, 8'h34, 1'b1);
    do_write(1, 3'd1, 8'h12, 1'b1);
    do_read(1, 3'd0, 1'b1, "R7 divisor low");
    do_read(1, 3'd1, 1'b1, "R7 divisor high");
    do_write(1, 3'd3, 8'h03, 1'b1);
    do_read(1, 3'd0, 1'b1, "R7 holding byte");
    do_read(1, 3'd1, 1'b1, "R7 enable register");
    // R8 ignored offsets and masked bits
    do_write(0, 3'd1, 8'hF5, 1'b1);
    do_write(0, 3'd5, 8'h00, 1'b1);
    do_read(0, 3'd1, 1'b1, "R8 enable mask");
    do_read(0, 3'd5, 1'b1, "R8 status offset unchanged");
    // R9 pending flag
    irq_src = 16'h0004;
    do_read(0, 3'd2, 1'b1, "R9 pending");
    irq_src = 16'h000A;
    do_read(0, 3'd2, 1'b1, "R9 not enabled");
    intsel = 1'b0; check_ints();
    do_write(3, 3'd4, 8'h08, 1'b1);
    check_ints();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h1c5_0454));
    bus_idle();
    addr = 0; data_in = 0; intsel = 0; irq_src = 0;
    mode16 = 1'b1; rst_pin = 1'b1;
    model_reset();
    enter_mode(1'b1);
    directed();
    // R5 split-strobe: high pin resets
    do_write(0, 3'd7, 8'h11, 1'b1);
    @(negedge clk); rst_pin = 1'b1; @(negedge clk); rst_pin = 1'b0; model_reset();
    do_read(0, 3'd7, 1'b1, "R5 high reset");
    random_phase(300);

    enter_mode(1'b0);
    directed();
    // R5 shared-select: low pin resets
    do_write(3, 3'd7, 8'h22, 1'b1);
    do_read(3, 3'd7, 1'b1, "R5 high pin no reset");
    @(negedge clk); rst_pin = 1'b0; @(negedge clk); rst_pin = 1'b1; model_reset();
    do_read(3, 3'd7, 1'b1, "R5 low reset");
    random_phase(300);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule